// File: doc/BRIEF.md
# Dual-Width Add, Subtract and Logic Unit with Condition Flags

This block is the integer execute stage of a scalar datapath. It takes two operands, a 3-bit operation code, a width select and a flag-update enable. It returns the result of an addition, a subtraction or one of six bitwise functions. The result path is purely combinational. A four-bit condition register holds negative, zero, carry and overflow, and it loads on a clock edge only when the enable is high and the operation is one of the flag-producing kinds.

The second operand arrives already shifted or extended by upstream logic. In narrow mode only the low `NARROW_W` bits of each operand take part, and the result leaves with every bit above the narrow width cleared. All condition bits are taken at the active width. In this unit the carry bit of a subtraction means a borrow: it is set when the second operand is the larger one.

Top module: `flagged_alu`

## Requirements
- R1: With op_sel 0 (add), result equals (a + b) modulo 2^w, where w is 64 in wide mode and 32 in narrow mode.
- R2: With op_sel 1 (subtract), result equals (a - b) modulo 2^w.
- R3: The bitwise codes give these results: 2 gives a AND b, 3 gives a AND NOT b, 4 gives a OR b, 5 gives a OR NOT b, 6 gives a XOR b, and 7 gives a XNOR b. Each result is taken at the active width.
- R4: When narrow is 1, result bits 63..32 are zero, and operand bits 63..32 have no effect on the result or on the flags.
- R5: After a flag update, flag_n equals the top bit of the result at the active width (bit 31 in narrow mode, bit 63 in wide mode).
- R6: After a flag update, flag_z is 1 exactly when the active-width result is zero.
- R7: After a flag-setting add, flag_c is 1 exactly when the unsigned sum overflows the active width.
- R8: After a flag-setting subtract, flag_c is 1 exactly when the unsigned b is greater than the unsigned a.
- R9: After a flag-setting add, flag_v is 1 exactly when a and b have the same sign and the result sign differs from it.
- R10: After a flag-setting subtract, flag_v is 1 exactly when a and b differ in sign and the result sign differs from the sign of a.
- R11: A flag-setting AND (code 2) or AND-NOT (code 3) clears flag_c and flag_v.
- R12: The flags keep their values across a clock edge when set_flags is 0, or when op_sel is 4, 5, 6 or 7.
- R13: While rst_n is low, all four flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low reset of the flags |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand, already shifted or extended |
| op_sel | input | 3 | Operation code (see R1 to R3) |
| narrow | input | 1 | 1 selects 32-bit operation, 0 selects 64-bit operation |
| set_flags | input | 1 | Requests a flag update on the next edge |
| result | output | 64 | Combinational result, zero-extended in narrow mode |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag (a borrow on subtract) |
| flag_v | output | 1 | Registered signed-overflow flag |

## Verification
On every cycle the checker tests the following:
- the cleared upper half in narrow mode;
- that the flags stay stable when no flag-producing update is requested;
- the negative and zero flags against the result port one edge earlier;
- the add carry, as a wrapped sum being smaller than the first operand;
- the subtract borrow, as a difference being larger than the first operand;
- the add overflow, from the operand and result signs;
- the cleared carry and overflow after a flag-setting logic operation.

Some behaviours show up only in the bench's directed scenarios: the exact result of each of the eight codes, subtract overflow at the signed boundaries, the flag values after reset, and the claim that upper operand bits have no effect in narrow mode.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_BIC  = 3'd3,
      OP_OR   = 3'd4,
      OP_ORN  = 3'd5,
      OP_XOR  = 3'd6,
      OP_XNOR = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } cond_flags_t;

   // Only arithmetic and the two AND-type codes may write the flags.
   function automatic logic op_writes_flags(alu_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_BIC);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic [WIDE_W-1:0] a,
   input  logic [WIDE_W-1:0] b,
   input  logic [WIDE_W-1:0] keep,
   input  logic              narrow,
   input  logic              do_sub,
   output logic [WIDE_W-1:0] sum,
   output logic              carry,
   output logic              ovf
);

   logic [WIDE_W-1:0] a_m;
   logic [WIDE_W-1:0] b_m;
   logic [WIDE_W-1:0] raw;
   logic              sgn_a;
   logic              sgn_b;
   logic              sgn_r;

   assign a_m = a & keep;
   assign b_m = b & keep;
   assign raw = do_sub ? (a_m - b_m) : (a_m + b_m);
   assign sum = raw & keep;

   // Add: carry when b exceeds the headroom left above a.
   // Subtract: borrow when b is the larger unsigned value.
   assign carry = do_sub ? (b_m > a_m) : (b_m > (keep - a_m));

   assign sgn_a = narrow ? a_m[NARROW_W-1] : a_m[WIDE_W-1];
   assign sgn_b = narrow ? b_m[NARROW_W-1] : b_m[WIDE_W-1];
   assign sgn_r = narrow ? sum[NARROW_W-1] : sum[WIDE_W-1];

   assign ovf = do_sub ? ((sgn_a != sgn_b) && (sgn_r != sgn_a))
                       : ((sgn_a == sgn_b) && (sgn_r != sgn_a));

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
   parameter int WIDE_W = 64
) (
   input  logic [WIDE_W-1:0] a,
   input  logic [WIDE_W-1:0] b,
   input  logic [1:0]        fn,
   input  logic              inv_b,
   output logic [WIDE_W-1:0] y
);

   // fn: 01 = AND, 10 = OR, 11 = XOR; inv_b complements b first.
   for (genvar i = 0; i < WIDE_W; i++) begin : g_bit
      logic bb;
      assign bb   = b[i] ^ inv_b;
      assign y[i] = (fn == 2'b01) ? (a[i] & bb) :
                    (fn == 2'b10) ? (a[i] | bb) :
                    (fn == 2'b11) ? (a[i] ^ bb) : 1'b0;
   end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  cond_flags_t d,
   output cond_flags_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end

endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
   import alu_pkg::*;
#(
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDE_W-1:0] opnd_a,
   input  logic [WIDE_W-1:0] opnd_b,
   input  logic [2:0]        op_sel,
   input  logic              narrow,
   input  logic              set_flags,
   output logic [WIDE_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v
);

   localparam int HIGH_W = WIDE_W - NARROW_W;

   if (NARROW_W < 1 || NARROW_W >= WIDE_W) begin : g_bad_width
      $error("flagged_alu: NARROW_W must lie between 1 and WIDE_W-1");
   end

   alu_op_e           op;
   logic              is_arith;
   logic [WIDE_W-1:0] keep;
   logic [WIDE_W-1:0] as_sum;
   logic              as_carry;
   logic              as_ovf;
   logic [WIDE_W-1:0] bw_y;
   cond_flags_t       fl_next;
   cond_flags_t       fl_q;

   assign op       = alu_op_e'(op_sel);
   assign is_arith = (op == OP_ADD) || (op == OP_SUB);
   assign keep     = narrow ? {{HIGH_W{1'b0}}, {NARROW_W{1'b1}}} : {WIDE_W{1'b1}};

   alu_addsub #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_addsub (
      .a      (opnd_a),
      .b      (opnd_b),
      .keep   (keep),
      .narrow (narrow),
      .do_sub (op == OP_SUB),
      .sum    (as_sum),
      .carry  (as_carry),
      .ovf    (as_ovf)
   );

   alu_bitwise #(.WIDE_W(WIDE_W)) u_bitwise (
      .a     (opnd_a),
      .b     (opnd_b),
      .fn    (op_sel[2:1]),
      .inv_b (op_sel[0]),
      .y     (bw_y)
   );

   assign result = is_arith ? as_sum : (bw_y & keep);

   always_comb begin
      fl_next.n = narrow ? result[NARROW_W-1] : result[WIDE_W-1];
      fl_next.z = ~|result;
      fl_next.c = is_arith & as_carry;
      fl_next.v = is_arith & as_ovf;
   end

   alu_flag_reg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (set_flags & op_writes_flags(op)),
      .d     (fl_next),
      .q     (fl_q)
   );

   assign flag_n = fl_q.n;
   assign flag_z = fl_q.z;
   assign flag_c = fl_q.c;
   assign flag_v = fl_q.v;

endmodule

// File: rtl/flagged_alu_chk.sv
module flagged_alu_chk #(
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WIDE_W-1:0] opnd_a,
   input logic [WIDE_W-1:0] opnd_b,
   input logic [2:0]        op_sel,
   input logic              narrow,
   input logic              set_flags,
   input logic [WIDE_W-1:0] result,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_c,
   input logic              flag_v
);

   logic [WIDE_W-1:0] msk;
   logic [WIDE_W-1:0] a_act;
   logic              upd;
   logic              sa;
   logic              sb;
   logic              sr;

   assign msk   = narrow ? {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}} : {WIDE_W{1'b1}};
   assign a_act = opnd_a & msk;
   assign upd   = set_flags && (op_sel <= 3'd3);
   assign sa    = narrow ? opnd_a[NARROW_W-1] : opnd_a[WIDE_W-1];
   assign sb    = narrow ? opnd_b[NARROW_W-1] : opnd_b[WIDE_W-1];
   assign sr    = narrow ? result[NARROW_W-1] : result[WIDE_W-1];

   p_upper_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      narrow |-> ((result & ~msk) == '0));

   p_neg_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (flag_n == $past(sr)));

   p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (flag_z == $past(result == '0)));

   p_add_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_flags && op_sel == 3'd0) |=> (flag_c == $past(result < a_act)));

   p_sub_borrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_flags && op_sel == 3'd1) |=> (flag_c == $past(result > a_act)));

   p_add_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_flags && op_sel == 3'd0) |=> (flag_v == $past((sa == sb) && (sr != sa))));

   p_logic_cv_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (set_flags && (op_sel == 3'd2 || op_sel == 3'd3)) |=> (!flag_c && !flag_v));

   p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable({flag_n, flag_z, flag_c, flag_v}));

endmodule

bind flagged_alu flagged_alu_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .op_sel    (op_sel),
   .narrow    (narrow),
   .set_flags (set_flags),
   .result    (result),
   .flag_n    (flag_n),
   .flag_z    (flag_z),
   .flag_c    (flag_c),
   .flag_v    (flag_v)
);

// File: tb/sim_flagged_alu.sv
`timescale 1ns/1ps
module sim_flagged_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic [2:0]  op_sel = '0;
   logic        narrow = 1'b0;
   logic        set_flags = 1'b0;
   logic [63:0] result;
   logic        flag_n, flag_z, flag_c, flag_v;

   int   n_checks = 0;
   int   n_fail = 0;
   logic [3:0] mflags = 4'b0000;   // {n,z,c,v} expected
   bit   done = 0;

   always #2.5 clk = ~clk;

   flagged_alu u0 (
      .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .op_sel(op_sel), .narrow(narrow), .set_flags(set_flags),
      .result(result), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Independent model of the requirements.
   task automatic model(input logic [63:0] a, input logic [63:0] b,
                        input logic [2:0] op, input logic nar,
                        output logic [63:0] r, output logic [3:0] f,
                        output logic upd);
      logic [64:0] am, bm, full;
      logic signed [65:0] sa, sb, sr, hi, lo;
      int w;
      w  = nar ? 32 : 64;
      am = nar ? {33'b0, a[31:0]} : {1'b0, a};
      bm = nar ? {33'b0, b[31:0]} : {1'b0, b};
      case (op)
         3'd0: full = am + bm;
         3'd1: full = am - bm;
         3'd2: full = am & bm;
         3'd3: full = am & ~bm;
         3'd4: full = am | bm;
         3'd5: full = am | ~bm;
         3'd6: full = am ^ bm;
         default: full = ~(am ^ bm);
      endcase
      r  = nar ? {32'b0, full[31:0]} : full[63:0];
      sa = nar ? 66'($signed(a[31:0])) : 66'($signed(a));
      sb = nar ? 66'($signed(b[31:0])) : 66'($signed(b));
      sr = (op == 3'd1) ? (sa - sb) : (sa + sb);
      hi = nar ? 66'sd2147483647 : 66'sd9223372036854775807;
      lo = -hi - 66'sd1;
      f[3] = r[w-1];
      f[2] = (r == 64'd0);
      if (op == 3'd0) begin
         f[1] = full[w];
         f[0] = (sr > hi) || (sr < lo);
      end else if (op == 3'd1) begin
         f[1] = (bm > am);
         f[0] = (sr > hi) || (sr < lo);
      end else begin
         f[1] = 1'b0;
         f[0] = 1'b0;
      end
      upd = (op <= 3'd3);
   endtask

   task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                         input logic [2:0] op, input logic nar, input logic sf,
                         input string req);
      logic [63:0] er;
      logic [3:0]  ef;
      logic        eu;
      @(negedge clk);
      opnd_a = a; opnd_b = b; op_sel = op; narrow = nar; set_flags = sf;
      model(a, b, op, nar, er, ef, eu);
      #1;
      check(req, "result", result, er);
      @(posedge clk);
      #1;
      if (sf && eu) mflags = ef;
      check(req, "flags nzcv", {60'b0, flag_n, flag_z, flag_c, flag_v}, {60'b0, mflags});
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R13", "flags in reset", {60'b0, flag_n, flag_z, flag_c, flag_v}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R13", "flags after reset", {60'b0, flag_n, flag_z, flag_c, flag_v}, 64'd0);
   endtask

   task automatic t_add();
      run_op(64'd5, 64'd7, 3'd0, 1'b0, 1'b1, "R1");
      run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'd0, 1'b0, 1'b1, "R7");
      run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 3'd0, 1'b0, 1'b1, "R9");
      run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 3'd0, 1'b0, 1'b1, "R9");
      run_op(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 3'd0, 1'b0, 1'b1, "R5");
   endtask

   task automatic t_sub();
      run_op(64'd10, 64'd3, 3'd1, 1'b0, 1'b1, "R2");
      run_op(64'd3, 64'd10, 3'd1, 1'b0, 1'b1, "R8");
      run_op(64'd42, 64'd42, 3'd1, 1'b0, 1'b1, "R6");
      run_op(64'h8000_0000_0000_0000, 64'd1, 3'd1, 1'b0, 1'b1, "R10");
      run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd1, 1'b0, 1'b1, "R10");
   endtask

   task automatic t_logic();
      for (int k = 2; k < 8; k++) begin
         run_op(64'hF0F0_CCCC_AAAA_1234, 64'hFF00_F0F0_5555_0FF0, 3'(k), 1'b0, 1'b0, "R3");
      end
   endtask

   task automatic t_logic_flags();
      run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'd0, 1'b0, 1'b1, "R7");
      run_op(64'h8000_0000_0000_00FF, 64'h8000_0000_0000_0F00, 3'd2, 1'b0, 1'b1, "R11");
      run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 3'd0, 1'b0, 1'b1, "R9");
      run_op(64'h00FF, 64'h00FF, 3'd3, 1'b0, 1'b1, "R11");
   endtask

   task automatic t_narrow();
      run_op(64'hDEAD_BEEF_FFFF_FFFF, 64'hCAFE_0000_0000_0001, 3'd0, 1'b1, 1'b1, "R4");
      run_op(64'h1111_1111_8000_0000, 64'h2222_2222_0000_0001, 3'd1, 1'b1, 1'b1, "R10");
      run_op(64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_0002, 3'd1, 1'b1, 1'b1, "R8");
      run_op(64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_0000_0001, 3'd0, 1'b1, 1'b1, "R9");
      run_op(64'h1234_5678_0F0F_0F0F, 64'hFFFF_FFFF_00FF_00FF, 3'd7, 1'b1, 1'b0, "R4");
      run_op(64'hABCD_0000_8000_0000, 64'h0000_FFFF_8000_0000, 3'd2, 1'b1, 1'b1, "R5");
   endtask

   task automatic t_hold();
      run_op(64'd3, 64'd10, 3'd1, 1'b0, 1'b1, "R8");
      run_op(64'd0, 64'd0, 3'd0, 1'b0, 1'b0, "R12");
      run_op(64'd0, 64'd0, 3'd4, 1'b0, 1'b1, "R12");
      run_op(64'd5, 64'd5, 3'd6, 1'b0, 1'b1, "R12");
      run_op(64'd0, 64'd0, 3'd5, 1'b0, 1'b1, "R12");
      run_op(64'd1, 64'd1, 3'd7, 1'b1, 1'b1, "R12");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_logic_flags();
      t_narrow();
      t_hold();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule